// File: doc/BRIEF.md
# Clock configuration and lock monitor

This block holds one 16-bit read/write clock control word and the small amount of logic that keeps it safe to use. It drives an external PLL model with a multiplier code, a reference divide-by-two select and a disable. It also drives selects for the core clock source, a PLL output pad enable, an RTC sleep control, two global clock dividers and three peripheral clock-gate enables. The analog PLL, the pads and the clock mux cells are outside the block. Only their control levels and the lock input cross its boundary.

Software writes the whole word in one bus cycle and reads it back at any time. Lock is sampled by a software sequence: the check bit is set and then cleared, and the lock input is captured on that clear. The captured status stays valid only while lock holds. The core clock switch accepts a change only while that status is valid and the USB clock select is not changing in the same write. Rejected switch changes raise a sticky error flag. The global dividers can be written only while the PLL is off, and they act only while it is off.

Top module: `clk_cfg_ctrl`

## Requirements
- R1: After reset the read word is 0x0000, all three gate enables are 1, `pll_off_o` is 1, both core source selects are 0 and `sw_err_o` is 0.
- R2: A write stores bits 15:12, 8, 7, 6, 4 and 3:0 as written. From the next clock the read word shows them, and `pll_mult_o` = bits 3:0, `pll_ref_div2_o` = bit 4, `vco_pad_en_o` = bit 7 and `rtc_sleep_o` = bit 12.
- R3: `pll_off_o` is 1 exactly when the multiplier field (bits 3:0) is zero. A nonzero value v requests a factor of v+1.
- R4: A write that clears the check bit (bit 8) while it is stored as 1 loads the lock status (bit 11) with `vco_lock_i` at that clock edge.
- R5: Any clock with `vco_lock_i` low clears the lock status. It stays 0 after lock returns until the next set-then-clear sequence on bit 8.
- R6: Bus writes to bit 11 have no effect.
- R7: A write that changes the clock switch (bit 5) while the lock status is 0 leaves bit 5 unchanged and sets `sw_err_o`.
- R8: A write that changes both bit 5 and the USB select (bit 6) leaves bit 5 unchanged, applies bit 6 and sets `sw_err_o`.
- R9: A write that changes bit 5 while the lock status is 1 and bit 6 is unchanged is applied. `core_src_vco_o` = bit5 AND NOT bit6, and `core_src_usb_o` = bit5 AND bit6.
- R10: While the stored multiplier is nonzero, the divider bits (bit 10 = divide by 256, bit 9 = divide by 2) are not writable. `gdiv256_en_o` and `gdiv2_en_o` follow their bits only while the multiplier is zero, and are 0 otherwise.
- R11: `gate_spdif_en_o`, `gate_stor_en_o` and `gate_usb_en_o` are the inverses of bits 15, 14 and 13. They change at the clock edge that accepts the write.
- R12: `sw_err_o` stays 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current control word with live lock status in bit 11 |
| vco_lock_i | input | 1 | Lock indication from the PLL model |
| pll_mult_o | output | 4 | Multiplier code to the PLL |
| pll_ref_div2_o | output | 1 | Reference divide-by-two select |
| pll_off_o | output | 1 | PLL disable (multiplier zero) |
| vco_pad_en_o | output | 1 | PLL clock pad driver enable |
| core_src_vco_o | output | 1 | Core clock taken from the vco |
| core_src_usb_o | output | 1 | Core clock taken from the USB clock |
| gdiv2_en_o | output | 1 | Effective global divide by 2 |
| gdiv256_en_o | output | 1 | Effective global divide by 256 |
| rtc_sleep_o | output | 1 | RTC sleep clocking mode |
| gate_spdif_en_o | output | 1 | Audio serial output clock enable |
| gate_stor_en_o | output | 1 | Storage/codec/buffer clock enable |
| gate_usb_en_o | output | 1 | USB clock enable |
| sw_err_o | output | 1 | Sticky rejected-switch flag |

## Verification
Every register result, including the stored word, the lock status, the error flag and the decoded outputs, is due at the first rising edge after the write or lock-input change. The combinational read path adds no further delay. The bench drives inputs on falling edges. It samples exactly one falling edge after a write strobe, and for lock-input changes one edge after the change. The persistence checks for the lock status and the error flag sample again after extra idle cycles.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int CFG_W   = 16;
  localparam int MULT_W  = 4;
  localparam int GATE_N  = 3;
  localparam int SYNC_N  = 2;

  // gate_off index: 2 = audio serial, 1 = storage, 0 = usb
  typedef struct packed {
    logic [GATE_N-1:0] gate_off;
    logic              rtc_sleep;
    logic              lock_st;
    logic              div256;
    logic              div2;
    logic              chk;
    logic              pad_en;
    logic              usb_sel;
    logic              sw;
    logic              ref_div;
    logic [MULT_W-1:0] mult;
  } cfg_t;
endpackage

// File: rtl/clk_cfg_wr_qual.sv
module clk_cfg_wr_qual
  import clk_cfg_pkg::*;
(
  input  logic wr_en,
  input  cfg_t cur,
  input  cfg_t wd,
  input  logic lock_ok,
  output cfg_t nxt,
  output logic sw_reject
);
  logic sw_chg;
  logic usb_chg;
  logic pll_on;

  assign sw_chg  = wd.sw != cur.sw;
  assign usb_chg = wd.usb_sel != cur.usb_sel;
  assign pll_on  = cur.mult != '0;

  always_comb begin
    nxt       = cur;
    sw_reject = 1'b0;
    if (wr_en) begin
      nxt.gate_off  = wd.gate_off;
      nxt.rtc_sleep = wd.rtc_sleep;
      nxt.chk       = wd.chk;
      nxt.pad_en    = wd.pad_en;
      nxt.usb_sel   = wd.usb_sel;
      nxt.ref_div   = wd.ref_div;
      nxt.mult      = wd.mult;
      nxt.lock_st   = wd.lock_st & 1'b0;
      if (!pll_on) begin
        nxt.div256 = wd.div256;
        nxt.div2   = wd.div2;
      end
      if (sw_chg) begin
        if (lock_ok && !usb_chg) begin
          nxt.sw = wd.sw;
        end else begin
          sw_reject = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clk_cfg_lock_mon.sv
module clk_cfg_lock_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic chk_cur,
  input  logic chk_nxt,
  input  logic vco_lock,
  output logic lock_ok
);
  logic lock_q;
  logic lock_d;
  logic lock_en;
  logic chk_fall;

  assign chk_fall = chk_cur & ~chk_nxt;

  always_comb begin
    lock_en = 1'b0;
    lock_d  = lock_q;
    if (chk_fall) begin
      lock_en = 1'b1;
      lock_d  = vco_lock;
    end else if (!vco_lock) begin
      lock_en = 1'b1;
      lock_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  assign lock_ok = lock_q;
endmodule

// File: rtl/clk_cfg_out_dec.sv
module clk_cfg_out_dec
  import clk_cfg_pkg::*;
(
  input  cfg_t              cfg,
  output logic [MULT_W-1:0] mult,
  output logic              ref_div2,
  output logic              pll_off,
  output logic              pad_en,
  output logic              src_vco,
  output logic              src_usb,
  output logic              gdiv2,
  output logic              gdiv256,
  output logic              rtc_sleep,
  output logic [GATE_N-1:0] gate_en
);
  assign mult      = cfg.mult;
  assign ref_div2  = cfg.ref_div;
  assign pll_off   = cfg.mult == '0;
  assign pad_en    = cfg.pad_en;
  assign src_vco   = cfg.sw & ~cfg.usb_sel;
  assign src_usb   = cfg.sw & cfg.usb_sel;
  assign gdiv2     = cfg.div2 & pll_off;
  assign gdiv256   = cfg.div256 & pll_off;
  assign rtc_sleep = cfg.rtc_sleep;

  for (genvar g = 0; g < GATE_N; g++) begin : g_gate
    assign gate_en[g] = ~cfg.gate_off[g];
  end
endmodule

// File: rtl/clk_cfg_ctrl.sv
module clk_cfg_ctrl
  import clk_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  output logic [CFG_W-1:0]  rd_data,
  input  logic              vco_lock_i,
  output logic [MULT_W-1:0] pll_mult_o,
  output logic              pll_ref_div2_o,
  output logic              pll_off_o,
  output logic              vco_pad_en_o,
  output logic              core_src_vco_o,
  output logic              core_src_usb_o,
  output logic              gdiv2_en_o,
  output logic              gdiv256_en_o,
  output logic              rtc_sleep_o,
  output logic              gate_spdif_en_o,
  output logic              gate_stor_en_o,
  output logic              gate_usb_en_o,
  output logic              sw_err_o
);
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_sync_n;
  cfg_t              cfg_q;
  cfg_t              cfg_d;
  cfg_t              wd_s;
  cfg_t              view;
  logic              sw_reject;
  logic              lock_ok;
  logic              err_q;
  logic              err_d;
  logic [GATE_N-1:0] gate_en;

  // reset: asserts at once, releases after SYNC_N edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  assign wd_s = cfg_t'(wr_data);

  clk_cfg_wr_qual u_qual (
    .wr_en     (wr_en),
    .cur       (cfg_q),
    .wd        (wd_s),
    .lock_ok   (lock_ok),
    .nxt       (cfg_d),
    .sw_reject (sw_reject)
  );

  clk_cfg_lock_mon u_lock (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .chk_cur  (cfg_q.chk),
    .chk_nxt  (cfg_d.chk),
    .vco_lock (vco_lock_i),
    .lock_ok  (lock_ok)
  );

  always_comb begin
    err_d = err_q | sw_reject;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en) begin
        cfg_q <= cfg_d;
        err_q <= err_d;
      end
    end
  end

  always_comb begin
    view         = cfg_q;
    view.lock_st = lock_ok;
  end
  assign rd_data  = CFG_W'(view);
  assign sw_err_o = err_q;

  clk_cfg_out_dec u_dec (
    .cfg       (cfg_q),
    .mult      (pll_mult_o),
    .ref_div2  (pll_ref_div2_o),
    .pll_off   (pll_off_o),
    .pad_en    (vco_pad_en_o),
    .src_vco   (core_src_vco_o),
    .src_usb   (core_src_usb_o),
    .gdiv2     (gdiv2_en_o),
    .gdiv256   (gdiv256_en_o),
    .rtc_sleep (rtc_sleep_o),
    .gate_en   (gate_en)
  );

  assign gate_spdif_en_o = gate_en[2];
  assign gate_stor_en_o  = gate_en[1];
  assign gate_usb_en_o   = gate_en[0];
endmodule

// File: rtl/clk_cfg_ctrl_chk.sv
module clk_cfg_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_gates,
  input logic       wr_sw,
  input logic       wr_usb,
  input logic       wr_chk,
  input logic [15:0] rd_data,
  input logic       vco_lock_i,
  input logic [2:0] gate_en,
  input logic       sw_err_o
);
  assert_lock_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_data[8] && !wr_chk && vco_lock_i) |=> rd_data[11]);

  assert_lock_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vco_lock_i |=> !rd_data[11]);

  assert_sw_hold_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[11] |=> $stable(rd_data[5]));

  assert_sw_usb_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sw != rd_data[5]) && (wr_usb != rd_data[6])) |=> ($stable(rd_data[5]) && sw_err_o));

  assert_div_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:0] != 4'd0) |=> $stable(rd_data[10:9]));

  assert_gate_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (gate_en == ~$past(wr_gates)));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_err_o |=> sw_err_o);
endmodule

bind clk_cfg_ctrl clk_cfg_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_gates   (wr_data[15:13]),
  .wr_sw      (wr_data[5]),
  .wr_usb     (wr_data[6]),
  .wr_chk     (wr_data[8]),
  .rd_data    (rd_data),
  .vco_lock_i (vco_lock_i),
  .gate_en    ({gate_spdif_en_o, gate_stor_en_o, gate_usb_en_o}),
  .sw_err_o   (sw_err_o)
);

// File: tb/clk_cfg_ctrl_tb_top.sv
module clk_cfg_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        vco_lock_i;
  logic [3:0]  pll_mult_o;
  logic        pll_ref_div2_o, pll_off_o, vco_pad_en_o;
  logic        core_src_vco_o, core_src_usb_o;
  logic        gdiv2_en_o, gdiv256_en_o, rtc_sleep_o;
  logic        gate_spdif_en_o, gate_stor_en_o, gate_usb_en_o, sw_err_o;

  int n_checks;
  int n_fail;
  bit finished;

  clk_cfg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .vco_lock_i(vco_lock_i), .pll_mult_o(pll_mult_o), .pll_ref_div2_o(pll_ref_div2_o),
    .pll_off_o(pll_off_o), .vco_pad_en_o(vco_pad_en_o), .core_src_vco_o(core_src_vco_o),
    .core_src_usb_o(core_src_usb_o), .gdiv2_en_o(gdiv2_en_o), .gdiv256_en_o(gdiv256_en_o),
    .rtc_sleep_o(rtc_sleep_o), .gate_spdif_en_o(gate_spdif_en_o),
    .gate_stor_en_o(gate_stor_en_o), .gate_usb_en_o(gate_usb_en_o), .sw_err_o(sw_err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 16'h0000;
  endtask

  task automatic set_lock(input logic v);
    @(negedge clk);
    vco_lock_i = v;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R1 rd_data", rd_data, 16'h0000);
    check("R1 gates", {13'd0, gate_spdif_en_o, gate_stor_en_o, gate_usb_en_o}, 16'h0007);
    check("R1 pll_off", {15'd0, pll_off_o}, 16'h0001);
    check("R1 core src", {14'd0, core_src_vco_o, core_src_usb_o}, 16'h0000);
    check("R1 err", {15'd0, sw_err_o}, 16'h0000);
  endtask

  task automatic t_plain_fields();
    bus_wr(16'hF0D5);
    check("R2 readback", rd_data, 16'hF0D5);
    check("R2 outs", {pll_mult_o, pll_ref_div2_o, vco_pad_en_o, rtc_sleep_o}, {4'd5, 3'b111});
    check("R3 pll_off nonzero", {15'd0, pll_off_o}, 16'h0000);
    check("R11 gates off", {13'd0, gate_spdif_en_o, gate_stor_en_o, gate_usb_en_o}, 16'h0000);
    bus_wr(16'hF8D5);
    check("R6 lock bit write ignored", rd_data, 16'hF0D5);
    bus_wr(16'hF6D5);
    check("R10 divider held while pll on", rd_data, 16'hF0D5);
    check("R10 divider outs", {14'd0, gdiv256_en_o, gdiv2_en_o}, 16'h0000);
    check("R12 no error yet", {15'd0, sw_err_o}, 16'h0000);
  endtask

  task automatic t_dividers();
    bus_wr(16'h0000);
    check("R3 pll_off zero", {15'd0, pll_off_o}, 16'h0001);
    bus_wr(16'h0600);
    check("R10 divider set pll off", rd_data, 16'h0600);
    check("R10 divider outs on", {14'd0, gdiv256_en_o, gdiv2_en_o}, 16'h0003);
    bus_wr(16'h0601);
    check("R10 pll enabled", rd_data, 16'h0601);
    check("R10 divider outs masked", {14'd0, gdiv256_en_o, gdiv2_en_o}, 16'h0000);
    bus_wr(16'h0001);
    check("R10 divider clear blocked", rd_data, 16'h0601);
    bus_wr(16'h0000);
    check("R10 mult cleared", rd_data, 16'h0600);
    bus_wr(16'h0000);
    check("R10 divider cleared", rd_data, 16'h0000);
  endtask

  task automatic t_lock_and_switch();
    set_lock(1'b1);
    bus_wr(16'h0101);
    check("R4 check set no status", rd_data, 16'h0101);
    bus_wr(16'h0001);
    check("R4 status captured", rd_data, 16'h0801);
    bus_wr(16'h0021);
    check("R9 switch accepted", rd_data, 16'h0821);
    check("R9 src vco", {14'd0, core_src_vco_o, core_src_usb_o}, 16'h0002);
    check("R9 no error", {15'd0, sw_err_o}, 16'h0000);
    bus_wr(16'h0041);
    check("R8 switch held usb applied", rd_data, 16'h0861);
    check("R8 error set", {15'd0, sw_err_o}, 16'h0001);
    check("R9 src usb", {14'd0, core_src_vco_o, core_src_usb_o}, 16'h0001);
    bus_wr(16'h0061);
    check("R12 error sticky", {15'd0, sw_err_o}, 16'h0001);
    set_lock(1'b0);
    check("R5 status cleared", {15'd0, rd_data[11]}, 16'h0000);
    set_lock(1'b1);
    repeat (2) @(negedge clk);
    check("R5 status stays cleared", {15'd0, rd_data[11]}, 16'h0000);
  endtask

  task automatic t_unlocked_switch();
    do_reset();
    check("R12 reset clears error", {15'd0, sw_err_o}, 16'h0000);
    set_lock(1'b0);
    bus_wr(16'h0101);
    bus_wr(16'h0001);
    check("R4 capture while unlocked", rd_data, 16'h0001);
    bus_wr(16'h0021);
    check("R7 switch rejected", rd_data, 16'h0001);
    check("R7 error set", {15'd0, sw_err_o}, 16'h0001);
  endtask

  task automatic t_gates();
    bus_wr(16'h8000);
    check("R11 audio gate", {13'd0, gate_spdif_en_o, gate_stor_en_o, gate_usb_en_o}, 16'h0003);
    bus_wr(16'h4000);
    check("R11 storage gate", {13'd0, gate_spdif_en_o, gate_stor_en_o, gate_usb_en_o}, 16'h0005);
    bus_wr(16'h2000);
    check("R11 usb gate", {13'd0, gate_spdif_en_o, gate_stor_en_o, gate_usb_en_o}, 16'h0006);
  endtask

  initial begin
    n_checks   = 0;
    n_fail     = 0;
    finished   = 1'b0;
    rst_n      = 1'b0;
    wr_en      = 1'b0;
    wr_data    = 16'h0000;
    vco_lock_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_plain_fields();
    t_dividers();
    t_lock_and_switch();
    t_unlocked_switch();
    t_gates();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule